// File: doc/BRIEF.md
# Direction-Aware DMA Bus Arbiter

This block decides which of several numbered DMA channels owns a single shared data bus. Every channel raises a request bit together with a direction bit that says whether its transfer reads or writes. Channels are ranked by number, and the lowest number is the most urgent. The arbiter also tracks which way the bus is currently moving. A request that would reverse the bus has its priority number worsened by a fixed penalty, so transfers that go the same way are kept together and read/write turnarounds become rarer.

The grouping is bounded by a traffic counter. The counter is loaded from a programmable value whenever the bus direction flips, and it counts down once for each transfer that completes. While the counter is non-zero, the penalty applies. When the counter reaches zero, plain fixed priority returns, so a waiting against-traffic request is served. An against-traffic request also wins as soon as no with-traffic request is present. A load value of zero turns grouping off. The owner of the bus signals that its transfer has finished with a one-cycle completion strobe. That strobe, or an idle bus, is the only moment at which the grant can move.

Top module: `dir_dma_arb`

## Requirements
- R1: While reset is high and in the first cycle after it, `grant_o` is all zeros and `bus_dir_o` is 0 (read).
- R2: When no channel is granted, the lowest-numbered requesting channel is granted on the next clock, whatever its direction. `bus_dir_o` takes that channel's direction in the same cycle.
- R3: `grant_o` has at most one bit set (bit i means channel i). A held grant does not change until `done_i` is pulsed, and `done_i` has no effect while nothing is granted.
- R4: When all requests go the same direction as the bus, the lowest-numbered request wins at each completion.
- R5: While the traffic counter is non-zero, 16 is added to the priority number of each request whose direction (`dir_i` bit, 1 = write, 0 = read) differs from `bus_dir_o`. Any with-traffic request therefore beats it.
- R6: An against-traffic request is granted at a completion when no with-traffic request is present, and `bus_dir_o` then flips.
- R7: The traffic counter is loaded from `reload_i` when the bus direction changes. It decreases by one on each completion that does not change direction. At zero, fixed priority applies and the waiting against-traffic request wins.
- R8: With a load value of zero, every direction change leaves the counter at zero, so plain fixed priority applies.
- R9: A completion with no pending request returns the grant to all zeros and leaves `bus_dir_o` unchanged.
- R10: Whenever a channel is newly granted, `bus_dir_o` equals that channel's requested direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_CH | Per-channel request |
| dir_i | input | N_CH | Per-channel direction, 1 = write, 0 = read |
| reload_i | input | CNT_W | Traffic counter load value, 0 disables grouping |
| done_i | input | 1 | One-cycle strobe: the granted transfer has finished |
| grant_o | output | N_CH | Registered one-hot grant |
| bus_dir_o | output | 1 | Registered current bus direction |

## Verification
The hardest state to reach is the moment the traffic counter expires while a lower-numbered against-traffic request is still waiting. That only happens after a direction change followed by exactly the programmed number of same-direction completions. The stimulus holds one low-numbered request against the traffic and keeps feeding higher-numbered with-traffic requests, one completion per cycle. It then checks the cycle in which the waiting channel takes over. A second sequence changes the load value in the middle of a group and confirms that the new value only matters at the next turnaround.

// File: rtl/dmaarb_pkg.sv
`timescale 1ns/1ps
package dmaarb_pkg;
  typedef enum logic {
    BUS_RD = 1'b0,
    BUS_WR = 1'b1
  } bus_dir_e;

  // priority-number penalty for a request that would turn the bus around
  localparam int unsigned TURN_PENALTY = 16;
endpackage

// File: rtl/dmaarb_eff_prio.sv
`timescale 1ns/1ps
module dmaarb_eff_prio #(
  parameter int unsigned N_CH = 8,
  parameter int unsigned PEN  = 16,
  parameter int unsigned EW   = 6
) (
  input  logic [N_CH-1:0]         dir_i,
  input  logic                    cur_dir_i,
  input  logic                    pen_en_i,
  output logic [N_CH-1:0][EW-1:0] eff_o
);
  // one priority number per channel: index, plus penalty when against traffic
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic against;
    assign against  = pen_en_i && (dir_i[i] != cur_dir_i);
    assign eff_o[i] = EW'(i) + (against ? EW'(PEN) : EW'(0));
  end
endmodule

// File: rtl/dmaarb_pick.sv
`timescale 1ns/1ps
module dmaarb_pick #(
  parameter int unsigned N_CH = 8,
  parameter int unsigned EW   = 6,
  parameter int unsigned IDXW = 3
) (
  input  logic [N_CH-1:0]         req_i,
  input  logic [N_CH-1:0][EW-1:0] eff_i,
  output logic                    any_o,
  output logic [N_CH-1:0]         onehot_o,
  output logic [IDXW-1:0]         idx_o
);
  logic [EW-1:0] best;

  // smallest effective number wins; strict compare keeps the lower index on a tie
  always_comb begin
    any_o = 1'b0;
    best  = '1;
    idx_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (req_i[i] && (!any_o || eff_i[i] < best)) begin
        any_o = 1'b1;
        best  = eff_i[i];
        idx_o = IDXW'(i);
      end
    end
    onehot_o = '0;
    if (any_o) onehot_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/dmaarb_traffic.sv
`timescale 1ns/1ps
module dmaarb_traffic
  import dmaarb_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             new_dir_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             dir_o,
  output logic             group_o
);
  bus_dir_e         dir_q;
  logic [CNT_W-1:0] cnt_q;
  logic             turn;

  assign turn = load_i && (bus_dir_e'(new_dir_i) != dir_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= BUS_RD;
      cnt_q <= '0;
    end else if (turn) begin
      dir_q <= bus_dir_e'(new_dir_i);
      cnt_q <= reload_i;
    end else if (done_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign dir_o   = dir_q;
  assign group_o = (cnt_q != '0);
endmodule

// File: rtl/dir_dma_arb.sv
`timescale 1ns/1ps
module dir_dma_arb
  import dmaarb_pkg::*;
#(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PEN   = TURN_PENALTY
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CH-1:0]  req_i,
  input  logic [N_CH-1:0]  dir_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             done_i,
  output logic [N_CH-1:0]  grant_o,
  output logic             bus_dir_o
);
  localparam int unsigned IDXW = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int unsigned EW   = $clog2(N_CH + PEN + 1) + 1;

  logic [N_CH-1:0]         grant_q;
  logic [N_CH-1:0][EW-1:0] eff;
  logic [N_CH-1:0]         win_onehot;
  logic [IDXW-1:0]         win_idx;
  logic                    win_any;
  logic                    idle, done_eff, arb_en, pen_en, group, cur_dir;

  assign idle     = ~|grant_q;
  assign done_eff = done_i & ~idle;
  assign arb_en   = idle | done_eff;
  // an idle bus lets the first request set the direction without penalty
  assign pen_en   = ~idle & group;

  dmaarb_eff_prio #(.N_CH(N_CH), .PEN(PEN), .EW(EW)) u_prio (
    .dir_i     (dir_i),
    .cur_dir_i (cur_dir),
    .pen_en_i  (pen_en),
    .eff_o     (eff)
  );

  dmaarb_pick #(.N_CH(N_CH), .EW(EW), .IDXW(IDXW)) u_pick (
    .req_i    (req_i),
    .eff_i    (eff),
    .any_o    (win_any),
    .onehot_o (win_onehot),
    .idx_o    (win_idx)
  );

  dmaarb_traffic #(.CNT_W(CNT_W)) u_traffic (
    .clk       (clk),
    .rst       (rst),
    .load_i    (arb_en & win_any),
    .new_dir_i (dir_i[win_idx]),
    .done_i    (done_eff),
    .reload_i  (reload_i),
    .dir_o     (cur_dir),
    .group_o   (group)
  );

  always_ff @(posedge clk) begin
    if (rst)         grant_q <= '0;
    else if (arb_en) grant_q <= win_onehot;
  end

  assign grant_o   = grant_q;
  assign bus_dir_o = cur_dir;
endmodule

// File: rtl/dir_dma_arb_chk.sv
`timescale 1ns/1ps
module dir_dma_arb_chk #(
  parameter int unsigned N_CH = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [N_CH-1:0] req_i,
  input logic [N_CH-1:0] dir_i,
  input logic            done_i,
  input logic [N_CH-1:0] grant_o,
  input logic            bus_dir_o
);
  logic [N_CH-1:0] low_req;
  assign low_req = req_i & (~req_i + 1'b1);

  assert_onehot_grant_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  assert_grant_held_R3: assert property (@(posedge clk) disable iff (rst)
    (grant_o != '0 && !done_i) |=> $stable(grant_o));

  assert_idle_lowest_R2: assert property (@(posedge clk) disable iff (rst)
    (grant_o == '0 && req_i != '0) |=> grant_o == $past(low_req));

  assert_dir_follows_R10: assert property (@(posedge clk) disable iff (rst)
    (grant_o == '0 && req_i != '0) |=> bus_dir_o == $past(|(low_req & dir_i)));

  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    (grant_o != '0 && done_i && req_i == '0) |=> grant_o == '0);
endmodule

bind dir_dma_arb dir_dma_arb_chk #(.N_CH(N_CH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_i     (req_i),
  .dir_i     (dir_i),
  .done_i    (done_i),
  .grant_o   (grant_o),
  .bus_dir_o (bus_dir_o)
);

// File: tb/dir_dma_arb_tb_top.sv
`timescale 1ns/1ps
module dir_dma_arb_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [N-1:0] dir = '0;
  logic [7:0]   reload = 8'd0;
  logic         done = 1'b0;
  logic [N-1:0] grant;
  logic         bdir;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  typedef struct {
    logic [N-1:0] g;
    logic         d;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;  // 125 MHz

  dir_dma_arb #(.N_CH(N), .CNT_W(8)) dut_i (
    .clk(clk), .rst(rst), .req_i(req), .dir_i(dir), .reload_i(reload),
    .done_i(done), .grant_o(grant), .bus_dir_o(bdir)
  );

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input logic [N-1:0] r, input logic [N-1:0] d,
                      input logic [7:0] rl, input logic dn,
                      input logic [N-1:0] eg, input logic ed, input string tag);
    exp_t e;
    @(negedge clk);
    req = r; dir = d; reload = rl; done = dn;
    e.g = eg; e.d = ed; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      checks++;
      if (grant !== e.g || bdir !== e.d) begin
        fails++;
        $display("FAIL %s: grant=%b dir=%b expected grant=%b dir=%b",
                 e.tag, grant, bdir, e.g, e.d);
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if (grant !== '0 || bdir !== 1'b0) begin
      fails++;
      $display("FAIL R1: grant=%b dir=%b expected grant=0 dir=0", grant, bdir);
    end
    rst = 1'b0;
    step(8'h00, 8'h00, 8'd2, 1'b0, 8'h00, 1'b0, "R1 after reset");
    // R2: idle, ch3 write and ch5 read -> ch3, bus goes write, counter=2
    step(8'h28, 8'h08, 8'd2, 1'b0, 8'h08, 1'b1, "R2 idle grant");
    // R3: no completion, grant held despite new requests
    step(8'h0A, 8'h08, 8'd2, 1'b0, 8'h08, 1'b1, "R3 hold");
    // R5: ch1 read vs ch6 write, counter 2 -> ch6, counter 1
    step(8'h42, 8'h40, 8'd2, 1'b1, 8'h40, 1'b1, "R5 with-traffic wins");
    // R5: ch1 read vs ch2 write, counter 1 -> ch2, counter 0
    step(8'h06, 8'h04, 8'd2, 1'b1, 8'h04, 1'b1, "R5 second group slot");
    // R7: counter expired -> ch1 read wins, bus turns, counter=2
    step(8'h06, 8'h04, 8'd2, 1'b1, 8'h02, 1'b0, "R7 timeout");
    // R5: ch0 write vs ch4 read with bus read -> ch4, counter 1
    step(8'h11, 8'h01, 8'd2, 1'b1, 8'h10, 1'b0, "R5 read group");
    // R6: only ch0 write remains -> granted, bus turns, counter=2
    step(8'h01, 8'h01, 8'd2, 1'b1, 8'h01, 1'b1, "R6 traffic stopped");
    // R9: completion with nothing pending -> idle, counter 1
    step(8'h00, 8'h00, 8'd2, 1'b1, 8'h00, 1'b1, "R9 release");
    // R2/R10: idle ignores penalty: ch2 read beats ch6 write, counter=2
    step(8'h44, 8'h40, 8'd2, 1'b1, 8'h04, 1'b0, "R10 idle turn");
    // R7: load value changes to 0 mid-group; counter 2 still penalises ch1 write
    step(8'h0A, 8'h02, 8'd0, 1'b1, 8'h08, 1'b0, "R7 counter 2->1");
    step(8'h0A, 8'h02, 8'd0, 1'b1, 8'h08, 1'b0, "R7 counter 1->0");
    // R7/R8: expired -> ch1 write, reload 0 keeps counter 0
    step(8'h0A, 8'h02, 8'd0, 1'b1, 8'h02, 1'b1, "R8 turn with zero load");
    // R8: plain priority: ch2 read beats ch4 write against bus
    step(8'h14, 8'h10, 8'd0, 1'b1, 8'h04, 1'b0, "R8 no grouping");
    step(8'h28, 8'h08, 8'd0, 1'b1, 8'h08, 1'b1, "R8 no grouping back");
    // R3: no completion, grant held
    step(8'h03, 8'h00, 8'd0, 1'b0, 8'h08, 1'b1, "R3 hold again");
    // R4: same direction, lowest index
    step(8'h70, 8'h70, 8'd0, 1'b1, 8'h10, 1'b1, "R4 lowest of three");
    step(8'h60, 8'h60, 8'd0, 1'b1, 8'h20, 1'b1, "R4 lowest of two");
    step(8'h00, 8'h00, 8'd0, 1'b1, 8'h00, 1'b1, "R9 release again");
    // R3: completion strobe while idle has no effect
    step(8'h00, 8'h00, 8'd0, 1'b1, 8'h00, 1'b1, "R3 idle done ignored");
    step(8'h00, 8'h00, 8'd0, 1'b0, 8'h00, 1'b1, "R9 stays idle");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule